// File: doc/BRIEF.md
# Keyed Configuration Port Listener

This block sits on an 8-bit I/O write bus of a legacy expansion card. It watches two fixed configuration ports. It stays locked until a five-byte key arrives in order. The first key byte goes to the unlock port and the remaining four go to the data port. The very next data-port write after a complete key is then taken as the configuration byte. That byte enables the card, picks its I/O base from a table of eight entries and selects an interrupt line.

Once enabled, the card claims a 16-byte window at the chosen base. A presence register inside that window lets software confirm that the card is there. Any read outside the window, or any read while the card is disabled, returns all ones. Two parameters choose the key set and the base table, so one netlist serves several board variants.

Top module: `cfgkey_listener`

## Requirements
- R1: After reset the card is disabled, the interrupt field and line are 0, the base is table entry 0, `win_hit` is low and reads return 0xFF.
- R2: A write to the unlock port (0x779) with key byte 0, then four writes to the data port (0x379) with key bytes 1 to 4 in order, arms the listener. The next data-port write is latched as the configuration byte.
- R3: A data-port write whose value differs from the expected key byte returns the listener to idle. A configuration write that follows it has no effect.
- R4: Any unlock-port write restarts the key. If the value equals key byte 0, byte 1 is expected next; otherwise the listener goes idle.
- R5: Only the single write after a completed key is latched. Later data-port writes leave the configuration unchanged until a new key is seen.
- R6: Writes to addresses other than the two configuration ports, and cycles without a write, do not disturb the key progress.
- R7: In the configuration byte, bit 7 is the enable, bits 6:4 are the interrupt field (`irq_field`) and bits 2:0 index the base table. Key set 1 is 0x0F,0x22,0xF0,0x20,0x80. Key set 0 is 0x59,0xB9,0xC5,0xAE,0xA6. Base table 0 is 0x280,0x290,0x300,0x310,0x330,0x340,0x348,0x350. Base table 1 is 0x220,0x240,0x280,0x2A0,0x2C0,0x300,0x320,0x340.
- R8: `irq_line` is 9 when the field is 2, 0 (no interrupt) when the field is 0, and equal to the field otherwise.
- R9: `win_hit` is high exactly when the card is enabled and `base <= io_addr <= base+15`, also for bases that are not 16-aligned.
- R10: Writing to window offset 9 stores bit 7 of the data. A read of offset 9 returns that bit in bit 7 with the other bits zero, so writing 0xC0 reads back 0x80. Other window offsets read 0x00.
- R11: A configuration byte with bit 7 clear disables the card. While the card is disabled, and for any address outside the window, reads return 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | I/O write strobe, one cycle per write |
| io_rd | input | 1 | I/O read strobe |
| io_addr | input | 16 | I/O address |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, 0xFF when not decoded |
| card_en | output | 1 | Card enable from the latched configuration |
| base_addr | output | 16 | Decoded window base |
| irq_field | output | 3 | Raw interrupt field |
| irq_line | output | 4 | Interrupt line number, 0 for none |
| win_hit | output | 1 | Address falls inside the enabled window |

## Verification
The bench builds the block with KEY_SET=1 and TABLE_SET=0. That pairing makes the second key set the only one that unlocks. It also puts bases 0x348 and 0x350 in the table. The 0x348 window crosses a 16-byte boundary, so the edges at 0x347, 0x357 and 0x358 test the subtractive decode rather than a simple upper-bit compare. Configuration bytes are chosen to cover interrupt fields 0, 1, 2 and 5, a disable byte, and key sequences broken by a wrong byte, by a restart and by foreign writes.

// File: rtl/cfgkey_pkg.sv
package cfgkey_pkg;

    typedef enum logic [2:0] {
        MS_IDLE  = 3'd0,
        MS_K1    = 3'd1,
        MS_K2    = 3'd2,
        MS_K3    = 3'd3,
        MS_K4    = 3'd4,
        MS_KEYED = 3'd5
    } mstate_t;

    typedef struct packed {
        logic       en;
        logic [2:0] irq;
        logic [2:0] idx;
    } cfg_t;

    function automatic logic [7:0] key_byte(input int set, input logic [2:0] pos);
        logic [7:0] b;
        if (set == 0) begin
            case (pos)
                3'd0:    b = 8'h59;
                3'd1:    b = 8'hB9;
                3'd2:    b = 8'hC5;
                3'd3:    b = 8'hAE;
                default: b = 8'hA6;
            endcase
        end else begin
            case (pos)
                3'd0:    b = 8'h0F;
                3'd1:    b = 8'h22;
                3'd2:    b = 8'hF0;
                3'd3:    b = 8'h20;
                default: b = 8'h80;
            endcase
        end
        return b;
    endfunction

    function automatic logic [15:0] base_of(input int set, input logic [2:0] idx);
        logic [15:0] a;
        if (set == 0) begin
            case (idx)
                3'd0:    a = 16'h0280;
                3'd1:    a = 16'h0290;
                3'd2:    a = 16'h0300;
                3'd3:    a = 16'h0310;
                3'd4:    a = 16'h0330;
                3'd5:    a = 16'h0340;
                3'd6:    a = 16'h0348;
                default: a = 16'h0350;
            endcase
        end else begin
            case (idx)
                3'd0:    a = 16'h0220;
                3'd1:    a = 16'h0240;
                3'd2:    a = 16'h0280;
                3'd3:    a = 16'h02A0;
                3'd4:    a = 16'h02C0;
                3'd5:    a = 16'h0300;
                3'd6:    a = 16'h0320;
                default: a = 16'h0340;
            endcase
        end
        return a;
    endfunction

endpackage

// File: rtl/cfgkey_matcher.sv
module cfgkey_matcher
    import cfgkey_pkg::*;
#(
    parameter int          KEY_SET     = 0,
    parameter int          AW          = 16,
    parameter logic [15:0] UNLOCK_PORT = 16'h0779,
    parameter logic [15:0] DATA_PORT   = 16'h0379
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic          cfg_load
);
    typedef struct packed {
        mstate_t st;
    } mstate_reg_t;

    mstate_reg_t m_d, m_q;
    logic on_unlock, on_data;

    assign on_unlock = wr && (addr == AW'(UNLOCK_PORT));
    assign on_data   = wr && (addr == AW'(DATA_PORT));

    always_comb begin
        m_d      = m_q;
        cfg_load = 1'b0;
        if (on_unlock) begin
            m_d.st = (wdata == key_byte(KEY_SET, 3'd0)) ? MS_K1 : MS_IDLE;
        end else if (on_data) begin
            case (m_q.st)
                MS_IDLE: m_d.st = MS_IDLE;
                MS_KEYED: begin
                    cfg_load = 1'b1;
                    m_d.st   = MS_IDLE;
                end
                default: begin
                    if (wdata == key_byte(KEY_SET, m_q.st))
                        m_d.st = mstate_t'(m_q.st + 3'd1);
                    else
                        m_d.st = MS_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) m_q <= '{st: MS_IDLE};
        else        m_q <= m_d;
    end

    // R4
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (on_unlock && wdata == key_byte(KEY_SET, 3'd0)) |=> (m_q.st == MS_K1));

    // R6
    quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!on_unlock && !on_data) |=> $stable(m_q.st));

    // R2
    state_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_q.st <= MS_KEYED);

endmodule

// File: rtl/cfgkey_latch.sv
module cfgkey_latch
    import cfgkey_pkg::*;
#(
    parameter int TABLE_SET = 0,
    parameter int AW        = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [7:0]    wdata,
    output logic          en,
    output logic [AW-1:0] base,
    output logic [2:0]    irq_field,
    output logic [3:0]    irq_line
);
    localparam logic [2:0] REMAP_FIELD = 3'd2;
    localparam logic [3:0] REMAP_LINE  = 4'd9;

    cfg_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (load) begin
            c_d.en  = wdata[7];
            c_d.irq = wdata[6:4];
            c_d.idx = wdata[2:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign en        = c_q.en;
    assign base      = AW'(base_of(TABLE_SET, c_q.idx));
    assign irq_field = c_q.irq;
    assign irq_line  = (c_q.irq == REMAP_FIELD) ? REMAP_LINE : {1'b0, c_q.irq};

    // R5
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(c_q));

    // R8
    irq_no_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_line != 4'd2);

endmodule

// File: rtl/cfgkey_window.sv
module cfgkey_window #(
    parameter int AW        = 16,
    parameter int WIN_SIZE  = 16,
    parameter int PROBE_OFS = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic          rd,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    input  logic          en,
    input  logic [AW-1:0] base,
    output logic          hit,
    output logic [7:0]    rdata
);
    typedef struct packed {
        logic present;
    } win_reg_t;

    win_reg_t w_d, w_q;
    logic [AW-1:0] ofs;
    logic          at_probe;

    assign ofs      = addr - base;
    assign hit      = en && (ofs < AW'(WIN_SIZE));
    assign at_probe = (ofs == AW'(PROBE_OFS));

    always_comb begin
        w_d = w_q;
        if (wr && hit && at_probe) w_d.present = wdata[7];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    always_comb begin
        rdata = 8'hFF;
        if (rd && hit) rdata = at_probe ? {w_q.present, 7'd0} : 8'h00;
    end

    // R10
    probe_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && hit && at_probe) |=> (w_q.present == $past(wdata[7])));

endmodule

// File: rtl/cfgkey_listener.sv
module cfgkey_listener #(
    parameter int KEY_SET   = 0,
    parameter int TABLE_SET = 0,
    parameter int AW        = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          io_wr,
    input  logic          io_rd,
    input  logic [AW-1:0] io_addr,
    input  logic [7:0]    io_wdata,
    output logic [7:0]    io_rdata,
    output logic          card_en,
    output logic [AW-1:0] base_addr,
    output logic [2:0]    irq_field,
    output logic [3:0]    irq_line,
    output logic          win_hit
);
    logic cfg_load;

    cfgkey_matcher #(.KEY_SET(KEY_SET), .AW(AW)) u_match (
        .clk(clk), .rst_n(rst_n), .wr(io_wr), .addr(io_addr),
        .wdata(io_wdata), .cfg_load(cfg_load)
    );

    cfgkey_latch #(.TABLE_SET(TABLE_SET), .AW(AW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .load(cfg_load), .wdata(io_wdata),
        .en(card_en), .base(base_addr), .irq_field(irq_field), .irq_line(irq_line)
    );

    cfgkey_window #(.AW(AW)) u_win (
        .clk(clk), .rst_n(rst_n), .wr(io_wr), .rd(io_rd), .addr(io_addr),
        .wdata(io_wdata), .en(card_en), .base(base_addr),
        .hit(win_hit), .rdata(io_rdata)
    );

    // R11
    closed_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !card_en |-> (io_rdata == 8'hFF && !win_hit));

endmodule

// File: tb/test_cfgkey_listener.sv
module test_cfgkey_listener;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [15:0] io_addr = 16'h0;
    logic [7:0]  io_wdata = 8'h0;
    logic [7:0]  io_rdata;
    logic        card_en;
    logic [15:0] base_addr;
    logic [2:0]  irq_field;
    logic [3:0]  irq_line;
    logic        win_hit;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    localparam logic [15:0] UNL = 16'h0779;
    localparam logic [15:0] DAT = 16'h0379;
    logic [7:0] key [5] = '{8'h0F, 8'h22, 8'hF0, 8'h20, 8'h80};

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } rd_item_t;
    rd_item_t sb[$];

    always #5 clk = ~clk;

    cfgkey_listener #(.KEY_SET(1), .TABLE_SET(0), .AW(16)) i_cfgkey_listener (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd),
        .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .card_en(card_en), .base_addr(base_addr), .irq_field(irq_field),
        .irq_line(irq_line), .win_hit(win_hit)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0; io_addr = 16'h0;
        #1;
    endtask

    task automatic rd(input logic [15:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        sb.push_back('{exp: exp, tag: tag});
        io_addr = a; io_rd = 1'b1;
        @(negedge clk);
        io_rd = 1'b0; io_addr = 16'h0;
    endtask

    task automatic hitchk(input logic [15:0] a, input logic exp, input string tag);
        @(negedge clk);
        io_addr = a;
        #1;
        chk(tag, win_hit, exp);
        io_addr = 16'h0;
    endtask

    task automatic full_key();
        wr(UNL, key[0]);
        for (int i = 1; i < 5; i++) wr(DAT, key[i]);
    endtask

    task automatic cfgchk(input string tag, input logic en, input logic [15:0] b,
                          input logic [2:0] f, input logic [3:0] l);
        chk({tag, " en"}, card_en, en);
        chk({tag, " base"}, base_addr, b);
        chk({tag, " field"}, irq_field, f);
        chk({tag, " line"}, irq_line, l);
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (io_rd) begin
                rd_item_t it;
                it = sb.pop_front();
                chk(it.tag, io_rdata, it.exp);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        cfgchk("R1 reset", 1'b0, 16'h0280, 3'd0, 4'd0);
        hitchk(16'h0289, 1'b0, "R1 no hit");
        rd(16'h0289, 8'hFF, "R1 read closed");

        // R2 / R7 unlock and configure: en, irq 5, idx 3
        full_key();
        wr(DAT, 8'hD3);
        cfgchk("R2 R7 cfg D3", 1'b1, 16'h0310, 3'd5, 4'd5);

        // R10 presence probe, R9 edges
        wr(16'h0319, 8'hC0);
        rd(16'h0319, 8'h80, "R10 probe readback");
        rd(16'h0310, 8'h00, "R10 other offset");
        rd(16'h0320, 8'hFF, "R11 above window");
        rd(16'h030F, 8'hFF, "R11 below window");
        hitchk(16'h031F, 1'b1, "R9 top edge");
        hitchk(16'h0320, 1'b0, "R9 past top");

        // R5 later data-port write ignored
        wr(DAT, 8'h00);
        cfgchk("R5 no relatch", 1'b1, 16'h0310, 3'd5, 4'd5);

        // R3 wrong byte returns to idle
        wr(UNL, key[0]);
        wr(DAT, key[1]);
        wr(DAT, 8'h55);
        wr(DAT, key[2]); wr(DAT, key[3]); wr(DAT, key[4]);
        wr(DAT, 8'h00);
        cfgchk("R3 broken key", 1'b1, 16'h0310, 3'd5, 4'd5);

        // R4 restart mid-sequence, then R8 field 2 -> line 9, unaligned base
        wr(UNL, key[0]);
        wr(DAT, key[1]);
        wr(UNL, key[0]);
        for (int i = 1; i < 5; i++) wr(DAT, key[i]);
        wr(DAT, 8'hA6);
        cfgchk("R4 R8 restart cfg A6", 1'b1, 16'h0348, 3'd2, 4'd9);
        hitchk(16'h0347, 1'b0, "R9 below 348");
        hitchk(16'h0350, 1'b1, "R9 across boundary");
        hitchk(16'h0357, 1'b1, "R9 top 348");
        hitchk(16'h0358, 1'b0, "R9 past 348");

        // R4 unlock write with wrong value goes idle
        wr(UNL, key[0]); wr(DAT, key[1]);
        wr(UNL, 8'h59);
        for (int i = 2; i < 5; i++) wr(DAT, key[i]);
        wr(DAT, 8'h00);
        cfgchk("R4 bad restart", 1'b1, 16'h0348, 3'd2, 4'd9);

        // R6 foreign writes and idle cycles interleaved
        wr(UNL, key[0]);
        wr(16'h0080, 8'hAA);
        wr(DAT, key[1]);
        repeat (3) @(negedge clk);
        wr(16'h0378, 8'h00);
        wr(DAT, key[2]); wr(DAT, key[3]);
        wr(16'h077A, 8'h11);
        wr(DAT, key[4]);
        wr(DAT, 8'h97);
        cfgchk("R6 R7 cfg 97", 1'b1, 16'h0350, 3'd1, 4'd1);

        // R11 disable
        full_key();
        wr(DAT, 8'h07);
        cfgchk("R11 disable", 1'b0, 16'h0350, 3'd0, 4'd0);
        rd(16'h0359, 8'hFF, "R11 disabled read");
        hitchk(16'h0350, 1'b0, "R11 disabled hit");

        // R8 field 0 -> no interrupt
        full_key();
        wr(DAT, 8'h84);
        cfgchk("R8 R7 cfg 84", 1'b1, 16'h0330, 3'd0, 4'd0);
        rd(16'h0339, 8'h80, "R10 presence kept");

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule